// File: doc/BRIEF.md
# Not-Equal-or-Zero Vector Comparator

This unit compares two 128-bit vector operands lane by lane. It can treat the operands as sixteen bytes, eight halfwords or four words. A lane of the result is filled with ones when the two lanes differ or when either of them is zero. It is filled with zeros only when both lanes hold the same nonzero value. A software loop that scans two strings can therefore locate the first mismatch and the first terminator with one operation.

A small decoder reads a sub-opcode and a minor code. From them it picks the lane width and the record option, or it flags the operation as illegal. The outputs are registered. They appear one cycle after the input strobe and come with an `outValid` pulse.

In record form the unit also writes a 4-bit condition field. One bit of this field says that every lane was true, and another says that no lane was true.

Top module: `vec_nez_cmp`

## Requirements
- R1: An operation is legal only when `subOp` equals 3 and `minorOp` is one of 4 (byte), 5 (halfword) or 6 (word), either alone or with bit 4 set (20, 21, 22). Bit 4 of `minorOp` selects record form. Every other pair of values is illegal.
- R2: In byte mode, lane i sits at bits [8i+7:8i] for i from 0 to 15. A result lane is all ones when lane A is zero, or lane B is zero, or the two lanes differ. Otherwise the result lane is all zeros.
- R3: In halfword mode the rule of R2 applies to eight 16-bit lanes, with lane i at bits [16i+15:16i].
- R4: In word mode the rule of R2 applies to four 32-bit lanes, with lane i at bits [32i+31:32i].
- R5: A legal record-form operation pulses `crWrEn` together with `outValid`. It also loads `crField[3]`, which is 1 exactly when every result lane is all ones.
- R6: The same record-form write loads `crField[1]`, which is 1 exactly when every result lane is zero. `crField[2]` and `crField[0]` are always 0.
- R7: A legal operation without record form leaves `crWrEn` low, and `crField` keeps its previous value.
- R8: An illegal operation drives `illegalOp` high with its `outValid` pulse, drives `result` to zero and leaves `crWrEn` low. `crField` keeps its previous value.
- R9: A strobe on `inValid` at a rising edge produces a one-cycle `outValid` pulse after that edge. Without a strobe, `outValid`, `crWrEn` and `illegalOp` are low and `result` holds its value.
- R10: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| subOp | input | 6 | Sub-opcode; the compare uses 3 |
| minorOp | input | 5 | Minor code: lane width in the low bits, record flag in bit 4 |
| opA | input | 128 | First vector operand |
| opB | input | 128 | Second vector operand |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 128 | Packed lane masks |
| crWrEn | output | 1 | Condition field was written this cycle |
| crField | output | 4 | Condition field: bit 3 all-true, bit 1 none-true |
| illegalOp | output | 1 | The strobed operation was not recognised |

## Verification
The bench builds the block with its default parameters: a 128-bit vector and an 8-bit base lane. These values give 16, 8 and 4 lanes, so lane 0 and the topmost lane of each width are both reached, and a zero lane can be placed on either side of a wider lane. Directed vectors cover both-zero, one-zero, all-equal-nonzero and all-differ inputs. Random vectors for each of the six legal codes perturb single bytes so that equal and unequal lanes mix.

// File: rtl/vnez_pkg.sv
package vnez_pkg;

  localparam int SUBOP_VCMP = 3;
  localparam int MINOR_BYTE = 4;
  localparam int MINOR_HALF = 5;
  localparam int MINOR_WORD = 6;
  localparam int REC_BIT    = 4;

  typedef enum logic [1:0] {
    ES_BYTE = 2'd0,
    ES_HALF = 2'd1,
    ES_WORD = 2'd2,
    ES_NONE = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      go;
    logic      illegal;
    logic      record;
    elemSize_e size;
  } cmdStrobe_t;

endpackage

// File: rtl/vnez_ctrl.sv
module vnez_ctrl
  import vnez_pkg::*;
#(
  parameter int SUB_W   = 6,
  parameter int MINOR_W = 5
) (
  input  logic               inValid,
  input  logic [SUB_W-1:0]   subOp,
  input  logic [MINOR_W-1:0] minorOp,
  output cmdStrobe_t         cmd
);

  localparam logic [MINOR_W-1:0] REC_MASK = MINOR_W'(1) << REC_BIT;

  logic [MINOR_W-1:0] baseCode;
  logic               subHit;
  elemSize_e          sizeDec;

  assign baseCode = minorOp & ~REC_MASK;
  assign subHit   = (subOp == SUB_W'(SUBOP_VCMP));

  always_comb begin
    case (baseCode)
      MINOR_W'(MINOR_BYTE): sizeDec = ES_BYTE;
      MINOR_W'(MINOR_HALF): sizeDec = ES_HALF;
      MINOR_W'(MINOR_WORD): sizeDec = ES_WORD;
      default:              sizeDec = ES_NONE;
    endcase
  end

  always_comb begin
    cmd.go      = inValid;
    cmd.illegal = !subHit || (sizeDec == ES_NONE);
    cmd.record  = minorOp[REC_BIT];
    cmd.size    = sizeDec;
  end

endmodule

// File: rtl/vnez_dpath.sv
module vnez_dpath
  import vnez_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BASE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobe_t       cmd,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             crWrEn,
  output logic [3:0]       crField,
  output logic             illegalOp
);

  localparam int N_SIZES = 3;

  logic [N_SIZES-1:0][VEC_W-1:0] sizeMask;
  logic [VEC_W-1:0]              laneMask;
  logic                          allSet;
  logic                          noneSet;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int LW = BASE_W << s;
    localparam int LN = VEC_W / LW;
    for (genvar i = 0; i < LN; i++) begin : g_lane
      logic [LW-1:0] laneA;
      logic [LW-1:0] laneB;
      logic          hit;
      assign laneA = opA[i*LW +: LW];
      assign laneB = opB[i*LW +: LW];
      assign hit   = (laneA == '0) || (laneB == '0) || (laneA != laneB);
      assign sizeMask[s][i*LW +: LW] = {LW{hit}};
    end
  end

  always_comb begin
    case (cmd.size)
      ES_BYTE: laneMask = sizeMask[0];
      ES_HALF: laneMask = sizeMask[1];
      ES_WORD: laneMask = sizeMask[2];
      default: laneMask = '0;
    endcase
  end

  assign allSet  = &laneMask;
  assign noneSet = ~|laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      crWrEn    <= 1'b0;
      crField   <= 4'b0000;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= cmd.go;
      crWrEn    <= 1'b0;
      illegalOp <= 1'b0;
      if (cmd.go) begin
        if (cmd.illegal) begin
          illegalOp <= 1'b1;
          result    <= '0;
        end else begin
          result <= laneMask;
          if (cmd.record) begin
            crWrEn  <= 1'b1;
            crField <= {allSet, 1'b0, noneSet, 1'b0};
          end
        end
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |=> outValid);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.go |=> (!outValid && !crWrEn && !illegalOp && $stable(result)));

  // R7
  cr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !crWrEn |-> $stable(crField));

  // R6
  cr_spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crField[2] == 1'b0) && (crField[0] == 1'b0));

  // R5
  cr_all_true_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && crField[3]) |-> (&result));

  // R6
  cr_none_true_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && crField[1]) |-> (result == '0));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && !crWrEn && (result == '0)));

endmodule

// File: rtl/vec_nez_cmp.sv
module vec_nez_cmp
  import vnez_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int BASE_W  = 8,
  parameter int SUB_W   = 6,
  parameter int MINOR_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SUB_W-1:0]   subOp,
  input  logic [MINOR_W-1:0] minorOp,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  output logic               outValid,
  output logic [VEC_W-1:0]   result,
  output logic               crWrEn,
  output logic [3:0]         crField,
  output logic               illegalOp
);

  cmdStrobe_t cmd;

  vnez_ctrl #(
    .SUB_W  (SUB_W),
    .MINOR_W(MINOR_W)
  ) i_ctrl (
    .inValid(inValid),
    .subOp  (subOp),
    .minorOp(minorOp),
    .cmd    (cmd)
  );

  vnez_dpath #(
    .VEC_W (VEC_W),
    .BASE_W(BASE_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .result   (result),
    .crWrEn   (crWrEn),
    .crField  (crField),
    .illegalOp(illegalOp)
  );

endmodule

// File: tb/test_vec_nez_cmp.sv
`timescale 1ns/1ps
module test_vec_nez_cmp;

  localparam int VW = 128;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [5:0]    subOp = '0;
  logic [4:0]    minorOp = '0;
  logic [VW-1:0] opA = '0;
  logic [VW-1:0] opB = '0;
  logic          outValid;
  logic [VW-1:0] result;
  logic          crWrEn;
  logic [3:0]    crField;
  logic          illegalOp;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [3:0] expCr = 4'b0000;

  always #2.5 clk = ~clk;

  vec_nez_cmp i_vec_nez_cmp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subOp(subOp),
    .minorOp(minorOp), .opA(opA), .opB(opB), .outValid(outValid),
    .result(result), .crWrEn(crWrEn), .crField(crField),
    .illegalOp(illegalOp)
  );

  // entry: {subOp, minorOp, A, B}
  localparam logic [6+5+2*VW-1:0] VEC_TAB [NV] = '{
    {6'd3, 5'd20, 128'h0, 128'h0},
    {6'd3, 5'd20, {16{8'h5a}}, {16{8'h5a}}},
    {6'd3, 5'd21, {{4{16'h1234}}, 16'h0000, {3{16'h1234}}}, {8{16'h1234}}},
    {6'd3, 5'd6,  {4{32'h11111111}}, {4{32'h22222222}}},
    {6'd3, 5'd22, {4{32'hcafe0001}}, {4{32'hcafe0001}}},
    {6'd3, 5'd4,  128'h00ff_0102_7777_0000_abcd_0001_ffff_1200, 128'h00ff_0102_7778_0000_abcd_0101_ffff_1200},
    {6'd3, 5'd5,  {8{16'h00a0}}, {{7{16'h00a0}}, 16'h0000}},
    {6'd3, 5'd7,  {16{8'h01}}, {16{8'h02}}},
    {6'd2, 5'd4,  {16{8'h01}}, {16{8'h02}}}
  };

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                          input int lw);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < VW / lw; i++) begin
      logic [VW-1:0] m;
      m = ((VW'(1) << lw) - VW'(1)) << (i * lw);
      if (((a & m) == '0) || ((b & m) == '0) || ((a & m) != (b & m))) r = r | m;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] so, input logic [4:0] mo,
                       input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic legal;
    logic rec;
    int lw;
    logic [VW-1:0] expRes;
    string rt;
    legal = (so == 6'd3) && (mo == 5'd4 || mo == 5'd5 || mo == 5'd6 ||
                             mo == 5'd20 || mo == 5'd21 || mo == 5'd22);
    rec = mo[4];
    lw = 8 << (mo % 4);
    rt = (lw == 8) ? "R2 byte" : (lw == 16) ? "R3 half" : "R4 word";
    expRes = legal ? model(a, b, lw) : '0;
    if (legal && rec) expCr = {(&expRes), 1'b0, (expRes == '0), 1'b0};
    @(negedge clk);
    subOp = so; minorOp = mo; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 outValid pulse", VW'(outValid), VW'(1));
    chk("R1 decode illegalOp", VW'(illegalOp), VW'(!legal));
    if (legal) chk(rt, result, expRes);
    else       chk("R8 illegal result", result, '0);
    if (legal && rec) begin
      chk("R5 crWrEn", VW'(crWrEn), VW'(1));
      chk("R5 R6 crField", VW'(crField), VW'(expCr));
    end else begin
      chk("R7 R8 crWrEn low", VW'(crWrEn), VW'(0));
      chk("R7 R8 crField held", VW'(crField), VW'(expCr));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] lastRes;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 reset outValid", VW'(outValid), VW'(0));
    chk("R10 reset result", result, '0);
    chk("R10 reset crWrEn", VW'(crWrEn), VW'(0));
    chk("R10 reset crField", VW'(crField), VW'(0));
    chk("R10 reset illegalOp", VW'(illegalOp), VW'(0));
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      issue(VEC_TAB[k][266:261], VEC_TAB[k][260:256],
            VEC_TAB[k][255:128], VEC_TAB[k][127:0]);
    end

    // random vectors for each legal code
    for (int c = 0; c < 6; c++) begin
      logic [4:0] mo;
      mo = (c < 3) ? 5'(4 + c) : 5'(20 + c - 3);
      for (int n = 0; n < 20; n++) begin
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        a = {$urandom(), $urandom(), $urandom(), $urandom()};
        b = a;
        for (int j = 0; j < 16; j++) begin
          if ($urandom() % 5 == 0) b[j*8 +: 8] = 8'($urandom());
          if ($urandom() % 9 == 0) a[j*8 +: 8] = 8'h00;
        end
        if (n == 0) begin a = '0; b = '0; end
        if (n == 1) b = a | {16{8'h01}};
        if (n == 2) begin a = a | {16{8'h01}}; b = a; end
        issue(6'd3, mo, a, b);
      end
    end

    // R9: no strobe -> no pulse, result holds
    lastRes = result;
    @(negedge clk);
    subOp = 6'd3; minorOp = 5'd20; opA = '0; opB = {16{8'h33}};
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle outValid", VW'(outValid), VW'(0));
    chk("R9 idle crWrEn", VW'(crWrEn), VW'(0));
    chk("R9 idle illegalOp", VW'(illegalOp), VW'(0));
    chk("R9 idle result held", result, lastRes);
    chk("R7 idle crField held", VW'(crField), VW'(expCr));

    // R7: non-record after an all-true record keeps crField
    issue(6'd3, 5'd20, '0, '0);
    issue(6'd3, 5'd4, {16{8'h44}}, {16{8'h44}});
    // R8: illegal after record keeps crField
    issue(6'd3, 5'd23, '0, '0);
    issue(6'd0, 5'd22, '0, '0);

    // R10: reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 mid reset crField", VW'(crField), VW'(0));
    chk("R10 mid reset result", result, '0);
    rstN = 1'b1;
    expCr = 4'b0000;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule